// File: doc/BRIEF.md
# T1 Transmit Clear-Channel Overwrite Gate

This block sits in a T1 transmit data path, between the source of channel octets and the framer. For every one of the 24 speech/data channels it decides whether the octet may be altered by robbed-bit signaling insertion and by zero code suppression (bit-7 stuffing). A 24-bit clear-channel mask, one bit per channel, is held in three byte-wide registers. While a channel's mask bit is clear, the two modifications are applied according to their own global enables. While it is set, the octet leaves the block exactly as it arrived.

Each input beat carries a valid flag, a zero-based channel index, the frame number within the 24-frame group, the signaling bit to insert and the octet itself. One registered stage produces the output octet and its valid flag. The framing and the signaling source are outside the block.

Top module: `clear_chan_gate`

## Requirements
- R1: After reset, all three mask registers read 0x00, `out_valid` is 0 and `out_octet` is 0x00.
- R2: Mask register address 0 holds channels 1..8, address 1 holds channels 9..16 and address 2 holds channels 17..24. Bit 0 of each register is the lowest channel of its group. `cfg_rdata` returns the register selected by `cfg_addr`. Writes to address 3 are ignored, and address 3 reads 0x00.
- R3: A mask write on a clock edge affects octets sampled on the following edges. An octet sampled on the same edge as the write still sees the old mask.
- R4: For an unmasked channel with `rob_en`=1, the octet's least significant bit is replaced by `in_sig` in frames 6, 12, 18 and 24. In every other frame number (0, 1..5, 7..11, 13..17, 19..23, 25..31) the octet is not changed by robbing.
- R5: For an unmasked channel with `zcs_en`=1, an octet that is all zero after signaling insertion is sent as 0x02. This is bit 7 in the MSB-first numbering 1..8, which is data bit index 1. Octets that are not zero are not changed by stuffing.
- R6: For a channel whose mask bit is 1, `out_octet` equals the input octet under every combination of `rob_en`, `zcs_en`, frame and signaling bit.
- R7: `rob_en` and `zcs_en` act independently. With `rob_en`=0 no robbing occurs. With `zcs_en`=0 no stuffing occurs, even when the result is 0x00.
- R8: Channel indices 24..31 are treated as clear channels, and their octets pass unchanged. `in_chan` value k means channel k+1.
- R9: `out_valid` equals `in_valid` one cycle later. `out_octet` updates only on a valid beat and otherwise holds its value. Bits 7..2 of the octet are never modified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Mask register write strobe |
| cfg_addr | input | 2 | Mask register address (0..2 valid) |
| cfg_wdata | input | 8 | Mask register write data |
| cfg_rdata | output | 8 | Mask register read data for `cfg_addr` |
| rob_en | input | 1 | Global enable for robbed-bit signaling |
| zcs_en | input | 1 | Global enable for zero code suppression |
| in_valid | input | 1 | Input beat valid |
| in_chan | input | 5 | Zero-based channel index |
| in_frame | input | 5 | Frame number 1..24 in the group |
| in_sig | input | 1 | Signaling bit to insert |
| in_octet | input | 8 | Channel octet |
| out_valid | output | 1 | Output beat valid |
| out_octet | output | 8 | Possibly modified octet |

## Verification
The bench builds the block with its default parameters: 24 channels, 8-bit octets and registers, a robbing period of 6 frames and a 24-frame group. At this size every channel index (including the out-of-range ones), every frame number from 0 to 31 and all four enable combinations can be swept for three mask patterns. The patterns are all clear, a mixed pattern and all masked. The octet set includes 0x00, 0x01 and 0x02, so robbing that creates a zero, stuffing after robbing and the single-bit boundary each occur in every frame class.

// File: rtl/ccg_pkg.sv
// Package: shared constants and helpers for the clear-channel gate.
// Assumes 1-based frame numbering within a signaling superframe.
package ccg_pkg;
    localparam int CCG_OCT_W = 8;

    // Returns 1 when the frame number carries robbed signaling bits.
    function automatic logic is_rob_frame(input int frame, input int period, input int sf_len);
        return (frame != 0) && (frame <= sf_len) && ((frame % period) == 0);
    endfunction
endpackage

// File: rtl/ccg_mask_regs.sv
// Module: ccg_mask_regs
// Holds the per-channel clear-channel mask as NUM_REG byte registers.
// Assumes registers above NUM_REG-1 are absent: writes ignored, reads zero.
module ccg_mask_regs #(
    parameter int NUM_CHAN = 24,
    parameter int REG_W    = 8,
    parameter int ADDR_W   = 2,
    localparam int NUM_REG = (NUM_CHAN + REG_W - 1) / REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic [NUM_CHAN-1:0] mask
);
    logic [NUM_REG*REG_W-1:0] flat;

    for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
        logic [REG_W-1:0] q;
        // Byte register r: reset to normal operation, load on matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (we && (int'(addr) == r))
                q <= wdata;
        end
        assign flat[r*REG_W +: REG_W] = q;
    end

    assign mask = flat[NUM_CHAN-1:0];

    // Readback multiplexer: unimplemented addresses read zero.
    always_comb begin
        rdata = '0;
        for (int r = 0; r < NUM_REG; r++)
            if (int'(addr) == r)
                rdata = flat[r*REG_W +: REG_W];
    end
endmodule

// File: rtl/ccg_rob_insert.sv
// Module: ccg_rob_insert
// Replaces the least significant bit with the signaling bit in robbed frames.
// Assumes the caller has already folded the clear-channel mask into 'enable'.
module ccg_rob_insert #(
    parameter int OCT_W   = 8,
    parameter int FRAME_W = 5,
    parameter int PERIOD  = 6,
    parameter int SF_LEN  = 24
) (
    input  logic               enable,
    input  logic [FRAME_W-1:0] frame,
    input  logic               sig,
    input  logic [OCT_W-1:0]   din,
    output logic [OCT_W-1:0]   dout
);
    import ccg_pkg::*;

    // Substitute bit 0 when enabled and the frame is a signaling frame.
    always_comb begin
        dout = din;
        if (enable && is_rob_frame(int'(frame), PERIOD, SF_LEN))
            dout[0] = sig;
    end
endmodule

// File: rtl/ccg_zcs_stuff.sv
// Module: ccg_zcs_stuff
// Forces the stuffing bit in an all-zero octet to keep ones density.
// Assumes it sits after signaling insertion in the data path.
module ccg_zcs_stuff #(
    parameter int OCT_W     = 8,
    parameter int STUFF_IDX = 1
) (
    input  logic             enable,
    input  logic [OCT_W-1:0] din,
    output logic [OCT_W-1:0] dout
);
    // Set the stuffing bit only for an all-zero octet.
    always_comb begin
        dout = din;
        if (enable && (din == '0))
            dout[STUFF_IDX] = 1'b1;
    end
endmodule

// File: rtl/clear_chan_gate.sv
// Module: clear_chan_gate
// Per-channel gate that blocks robbed-bit signaling and zero code
// suppression on clear channels, followed by one output register stage.
// Assumes in_chan is zero-based; indices at or above NUM_CHAN are clear.
module clear_chan_gate #(
    parameter int NUM_CHAN  = 24,
    parameter int OCT_W     = 8,
    parameter int REG_W     = 8,
    parameter int ADDR_W    = 2,
    parameter int CHAN_W    = 5,
    parameter int FRAME_W   = 5,
    parameter int ROB_PER   = 6,
    parameter int SF_LEN    = 24,
    parameter int STUFF_IDX = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [REG_W-1:0]   cfg_wdata,
    output logic [REG_W-1:0]   cfg_rdata,
    input  logic               rob_en,
    input  logic               zcs_en,
    input  logic               in_valid,
    input  logic [CHAN_W-1:0]  in_chan,
    input  logic [FRAME_W-1:0] in_frame,
    input  logic               in_sig,
    input  logic [OCT_W-1:0]   in_octet,
    output logic               out_valid,
    output logic [OCT_W-1:0]   out_octet
);
    localparam int IDX_N = 1 << CHAN_W;

    logic [NUM_CHAN-1:0] mask;
    logic [IDX_N-1:0]    mask_ext;
    logic                chan_clear;
    logic [OCT_W-1:0]    robbed;
    logic [OCT_W-1:0]    stuffed;

    ccg_mask_regs #(
        .NUM_CHAN(NUM_CHAN), .REG_W(REG_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .mask(mask)
    );

    // Pad the mask so out-of-range channel indices read as clear.
    if (IDX_N > NUM_CHAN) begin : g_pad
        assign mask_ext = {{(IDX_N - NUM_CHAN){1'b1}}, mask};
    end else begin : g_nopad
        assign mask_ext = mask[IDX_N-1:0];
    end

    assign chan_clear = mask_ext[in_chan];

    ccg_rob_insert #(
        .OCT_W(OCT_W), .FRAME_W(FRAME_W), .PERIOD(ROB_PER), .SF_LEN(SF_LEN)
    ) u_rob (
        .enable(rob_en && !chan_clear), .frame(in_frame), .sig(in_sig),
        .din(in_octet), .dout(robbed)
    );

    ccg_zcs_stuff #(
        .OCT_W(OCT_W), .STUFF_IDX(STUFF_IDX)
    ) u_zcs (
        .enable(zcs_en && !chan_clear), .din(robbed), .dout(stuffed)
    );

    // Output stage: valid follows input, octet loads only on valid beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_octet <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_octet <= stuffed;
        end
    end
endmodule

// File: rtl/ccg_checker.sv
// Module: ccg_checker
// Temporal checks on the clear-channel gate, attached by bind.
module ccg_checker #(
    parameter int NUM_CHAN = 24,
    parameter int OCT_W    = 8,
    parameter int CHAN_W   = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rob_en,
    input logic                zcs_en,
    input logic                in_valid,
    input logic [CHAN_W-1:0]   in_chan,
    input logic [OCT_W-1:0]    in_octet,
    input logic [NUM_CHAN-1:0] mask,
    input logic                out_valid,
    input logic [OCT_W-1:0]    out_octet
);
    logic is_clear;
    // Independent view of whether the sampled channel is clear.
    always_comb begin
        is_clear = 1'b1;
        for (int c = 0; c < NUM_CHAN; c++)
            if (int'(in_chan) == c)
                is_clear = mask[c];
    end

    assert_valid_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_octet));
    assert_upper_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_octet[OCT_W-1:2] == $past(in_octet[OCT_W-1:2]));
    assert_clear_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && is_clear |=> out_octet == $past(in_octet));
    assert_off_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !rob_en && !zcs_en |=> out_octet == $past(in_octet));
    assert_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && zcs_en && !is_clear |=> out_octet != '0);
endmodule

bind clear_chan_gate ccg_checker #(
    .NUM_CHAN(NUM_CHAN), .OCT_W(OCT_W), .CHAN_W(CHAN_W)
) u_ccg_checker (
    .clk(clk), .rst_n(rst_n), .rob_en(rob_en), .zcs_en(zcs_en),
    .in_valid(in_valid), .in_chan(in_chan), .in_octet(in_octet),
    .mask(mask), .out_valid(out_valid), .out_octet(out_octet)
);

// File: tb/test_clear_chan_gate.sv
`timescale 1ns/1ps
module test_clear_chan_gate;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       rob_en = 1'b0, zcs_en = 1'b0;
    logic       in_valid = 1'b0;
    logic [4:0] in_chan = '0, in_frame = '0;
    logic       in_sig = 1'b0;
    logic [7:0] in_octet = '0;
    logic       out_valid;
    logic [7:0] out_octet;

    int checks = 0;
    int errors = 0;
    logic [23:0] mask_m = '0;

    always #2.5 clk = ~clk;

    clear_chan_gate i_clear_chan_gate (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rob_en(rob_en),
        .zcs_en(zcs_en), .in_valid(in_valid), .in_chan(in_chan),
        .in_frame(in_frame), .in_sig(in_sig), .in_octet(in_octet),
        .out_valid(out_valid), .out_octet(out_octet)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
        @(negedge clk);
        cfg_addr = a;
        #1 chk(req, cfg_rdata, exp);
    endtask

    // Model from the requirements: returns the octet expected at the output.
    function automatic logic [7:0] model(input int ch, input int fr, input logic sg,
                                         input logic [7:0] oc, input logic re, input logic ze);
        logic [7:0] v = oc;
        logic clr = (ch >= 24) ? 1'b1 : mask_m[ch];
        if (!clr && re && (fr == 6 || fr == 12 || fr == 18 || fr == 24)) v[0] = sg;
        if (!clr && ze && v == 8'h00) v = 8'h02;
        return v;
    endfunction

    task automatic beat(input int ch, input int fr, input logic sg, input logic [7:0] oc,
                        input logic re, input logic ze);
        logic [7:0] e;
        string tag;
        @(negedge clk);
        in_valid = 1'b1; in_chan = ch[4:0]; in_frame = fr[4:0];
        in_sig = sg; in_octet = oc; rob_en = re; zcs_en = ze;
        e = model(ch, fr, sg, oc, re, ze);
        if (ch >= 24) tag = "R8";
        else if (mask_m[ch]) tag = "R6";
        else if (re && (fr % 6 == 0) && fr != 0 && fr <= 24) tag = "R4";
        else if (ze) tag = "R5";
        else tag = "R7";
        @(posedge clk);
        #1;
        chk("R9 valid", {7'd0, out_valid}, 8'h01);
        chk(tag, out_octet, e);
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] pat [8] = '{8'h00, 8'h01, 8'h02, 8'hFF, 8'h80, 8'h7E, 8'h03, 8'h55};
        logic [23:0] masks [3] = '{24'h000000, 24'h5A0F81, 24'hFFFFFF};
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 out_valid", {7'd0, out_valid}, 8'h00);
        chk("R1 out_octet", out_octet, 8'h00);
        for (int a = 0; a < 3; a++) rd_chk("R1 mask", a[1:0], 8'h00);

        // R2 register layout and readback
        wr(2'd0, 8'h81); wr(2'd1, 8'h0F); wr(2'd2, 8'h5A);
        rd_chk("R2 addr0", 2'd0, 8'h81);
        rd_chk("R2 addr1", 2'd1, 8'h0F);
        rd_chk("R2 addr2", 2'd2, 8'h5A);
        wr(2'd3, 8'hFF);
        rd_chk("R2 addr3", 2'd3, 8'h00);
        rd_chk("R2 addr0 kept", 2'd0, 8'h81);
        rd_chk("R2 addr2 kept", 2'd2, 8'h5A);
        mask_m = 24'h5A0F81;
        // R2: channel 1 (bit 0 addr 0) clear, channel 2 normal, channel 24 (addr2 bit7) normal
        beat(0, 1, 1'b0, 8'h00, 1'b0, 1'b1);
        beat(1, 1, 1'b0, 8'h00, 1'b0, 1'b1);
        beat(23, 1, 1'b0, 8'h00, 1'b0, 1'b1);

        // R3: write and beat on the same edge see the old mask
        wr(2'd0, 8'h00);
        mask_m = 24'h5A0F00;
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 8'h01;
        in_valid = 1'b1; in_chan = 5'd0; in_frame = 5'd1; in_octet = 8'h00;
        rob_en = 1'b0; zcs_en = 1'b1;
        @(posedge clk); #1;
        chk("R3 old mask", out_octet, 8'h02);
        @(negedge clk);
        cfg_we = 1'b0;
        @(posedge clk); #1;
        chk("R3 new mask", out_octet, 8'h00);

        // R9: idle beat holds the octet and drops valid
        beat(5, 3, 1'b0, 8'h3C, 1'b1, 1'b1);
        @(negedge clk);
        in_valid = 1'b0; in_octet = 8'h00; in_chan = 5'd5;
        @(posedge clk); #1;
        chk("R9 valid low", {7'd0, out_valid}, 8'h00);
        chk("R9 hold", out_octet, 8'h3C);

        // Sweep: masks x enables x channels x frames
        for (int m = 0; m < 3; m++) begin
            wr(2'd0, masks[m][7:0]); wr(2'd1, masks[m][15:8]); wr(2'd2, masks[m][23:16]);
            mask_m = masks[m];
            for (int en = 0; en < 4; en++)
                for (int ch = 0; ch < 32; ch++)
                    for (int fr = 0; fr < 32; fr++)
                        beat(ch, fr, logic'((ch + fr + m) & 1),
                             pat[(ch * 7 + fr * 3 + en) % 8], en[0], en[1]);
        end

        @(negedge clk);
        in_valid = 1'b0;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule